// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block turns a snapshot of clock-configuration fields into the frequencies, in Hz, that a fixed clock tree would produce from a 24 MHz reference. The tree runs in a fixed order. A system PLL multiplies the reference by 20 or 22. Two fractional dividers scale the PLL output by 18/N. A four-way source mux picks the peripheral root. Three cascaded (N+1) post-dividers then produce the bus, register-bus and timer frequencies. Timer and driver models in the rest of the chip use it to learn their tick rates.

A one-cycle `start` pulse latches the configuration inputs. The block then runs its divisions one after another on a single shared restoring divider. At the end it raises `done`, and the three 32-bit results stay in place until the next accepted start. If the selected fractional divider holds zero, the block skips the arithmetic and reports an error. Two constant outputs give the reference frequency and the reference divided by eight.

Top module: `ccalc_clktree_freq`

## Requirements
- R1: After reset `busy`, `done` and `err` are 0 and `ahb_hz`, `ipg_hz`, `per_hz` are 0.
- R2: The PLL frequency is 24,000,000 × 22 when `pll_hi` is 1 and 24,000,000 × 20 when it is 0. With `src_sel` = 0 the peripheral root is the PLL frequency.
- R3: With `src_sel` = 1 the root is floor(PLL × 18 / `frac2`). With `src_sel` = 2 it is floor(PLL × 18 / `frac0`). With `src_sel` = 3 it is floor(floor(PLL × 18 / `frac2`) / 2). Intermediates are 64 bits wide.
- R4: `ahb_hz` = floor(root / (`ahb_div`+1)), `ipg_hz` = floor(ahb / (`ipg_div`+1)) and `per_hz` = floor(ipg / (`per_div`+1)). Each stage divides the unsaturated value of the stage before it.
- R5: Any result above 4,294,967,295 is reported as 0xFFFFFFFF.
- R6: If the fraction field selected by `src_sel` (1 and 3 use `frac2`, 2 uses `frac0`) is zero, then on the clock edge that accepts `start` the block sets `done` = 1 and `err` = 1 and clears all three results to 0. A zero in the fraction field that is not selected has no effect.
- R7: Once `done` is 1, it stays 1 until the next `start`. While it stays 1, the results and `err` do not change, even if the configuration inputs change.
- R8: A `start` pulse while `busy` is 1 is ignored. The configuration is sampled only at an accepted start.
- R9: `ref_hz` is always 24,000,000 and `ref_div_hz` is always 3,000,000.
- R10: After an accepted error-free start, `busy` is 1 from the next cycle until `done` rises. `done` and `busy` are never both 1. `done` rises no more than 4×64+16 cycles after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; latches the configuration |
| pll_hi | input | 1 | PLL multiplier select (1: ×22, 0: ×20) |
| src_sel | input | 2 | Peripheral root source select |
| frac0 | input | 6 | Fraction field of fractional output 0 |
| frac2 | input | 6 | Fraction field of fractional output 2 |
| ahb_div | input | 3 | Bus post-divider field (divide by N+1) |
| ipg_div | input | 2 | Register-bus post-divider field |
| per_div | input | 6 | Timer post-divider field |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | Results valid |
| err | output | 1 | Selected fraction field was zero |
| ahb_hz | output | 32 | Bus clock frequency in Hz |
| ipg_hz | output | 32 | Register-bus clock frequency in Hz |
| per_hz | output | 32 | Timer clock frequency in Hz |
| ref_hz | output | 32 | Reference frequency |
| ref_div_hz | output | 32 | Reference frequency divided by eight |

## Verification
Each stage feeds the next, so a wrong remainder or a bit slip in the shared divider rarely stays local. It shows up in the same run at the port of that stage and again in every later result. The single `done` edge of that run exposes it. A stage counter that steers the wrong divisor or skips a stage gives a wrong bus, register-bus or timer value, or a `done` that comes too early or too late by a whole division (about 66 cycles). The sweeps pair every source, both PLL settings and every bus divider with several fraction values, so each stage is checked against a value the bench computes itself.

// File: rtl/ccalc_pkg.sv
package ccalc_pkg;
  localparam int unsigned REF_HZ     = 24_000_000;
  localparam int unsigned PLL_MUL_LO = 20;
  localparam int unsigned PLL_MUL_HI = 22;
  localparam int unsigned FRAC_MUL   = 18;
  localparam int unsigned REF_DIV    = 8;

  typedef enum logic [1:0] {
    SRC_PLL      = 2'd0,
    SRC_FR2      = 2'd1,
    SRC_FR0      = 2'd2,
    SRC_FR2_HALF = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    STG_FRAC = 2'd0,
    STG_AHB  = 2'd1,
    STG_IPG  = 2'd2,
    STG_PER  = 2'd3
  } stage_e;
endpackage

// File: rtl/ccalc_div.sv
module ccalc_div #(
  parameter int DW = 64,
  parameter int VW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] num,
  input  logic [VW-1:0] den,
  output logic          fin,
  output logic [DW-1:0] quo
);
  localparam int CW = $clog2(DW + 1);

  logic [VW-1:0] rem;
  logic [CW-1:0] cnt;
  logic [VW:0]   trial;
  logic [VW:0]   diff;

  assign trial = {rem, quo[DW-1]};
  assign diff  = trial - {1'b0, den};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      quo <= '0;
      cnt <= '0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        quo <= num;
        rem <= '0;
        cnt <= CW'(DW);
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
        if (trial >= {1'b0, den}) begin
          rem <= diff[VW-1:0];
          quo <= {quo[DW-2:0], 1'b1};
        end else begin
          rem <= trial[VW-1:0];
          quo <= {quo[DW-2:0], 1'b0};
        end
        if (cnt == CW'(1)) fin <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ccalc_ctrl.sv
module ccalc_ctrl
  import ccalc_pkg::*;
#(
  parameter int FRAC_W = 6,
  parameter int AHB_W  = 3,
  parameter int IPG_W  = 2,
  parameter int PER_W  = 6,
  parameter int OW     = 32,
  parameter int DW     = 64,
  parameter int VW     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pll_hi,
  input  logic [1:0]        src_sel,
  input  logic [FRAC_W-1:0] frac0,
  input  logic [FRAC_W-1:0] frac2,
  input  logic [AHB_W-1:0]  ahb_div,
  input  logic [IPG_W-1:0]  ipg_div,
  input  logic [PER_W-1:0]  per_div,
  output logic              div_go,
  output logic [DW-1:0]     div_num,
  output logic [VW-1:0]     div_den,
  input  logic              div_fin,
  input  logic [DW-1:0]     div_quo,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [OW-1:0]     ahb_hz,
  output logic [OW-1:0]     ipg_hz,
  output logic [OW-1:0]     per_hz
);
  logic              run, issued;
  stage_e            stg;
  logic              half_q;
  logic [FRAC_W-1:0] frac_q;
  logic [AHB_W-1:0]  ahb_q;
  logic [IPG_W-1:0]  ipg_q;
  logic [PER_W-1:0]  per_q;
  logic [DW-1:0]     cur;
  logic [OW-1:0]     ahb_s, ipg_s;
  logic [DW-1:0]     pll_hz;
  logic [FRAC_W-1:0] frac_pick;
  logic              frac_bad;

  function automatic logic [OW-1:0] sat(input logic [DW-1:0] v);
    return (v > DW'({OW{1'b1}})) ? {OW{1'b1}} : v[OW-1:0];
  endfunction

  assign pll_hz    = DW'(REF_HZ) * (pll_hi ? DW'(PLL_MUL_HI) : DW'(PLL_MUL_LO));
  assign frac_pick = (src_sel == SRC_FR0) ? frac0 : frac2;
  assign frac_bad  = (src_sel != SRC_PLL) && (frac_pick == '0);
  assign div_go    = run && !issued;
  assign div_num   = cur;
  assign busy      = run;

  always_comb begin
    case (stg)
      STG_FRAC: div_den = VW'(frac_q);
      STG_AHB:  div_den = VW'(ahb_q) + VW'(1);
      STG_IPG:  div_den = VW'(ipg_q) + VW'(1);
      default:  div_den = VW'(per_q) + VW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      issued <= 1'b0;
      stg    <= STG_FRAC;
      half_q <= 1'b0;
      frac_q <= '0;
      ahb_q  <= '0;
      ipg_q  <= '0;
      per_q  <= '0;
      cur    <= '0;
      ahb_s  <= '0;
      ipg_s  <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      ahb_hz <= '0;
      ipg_hz <= '0;
      per_hz <= '0;
    end else if (start && !run) begin
      if (frac_bad) begin
        done   <= 1'b1;
        err    <= 1'b1;
        ahb_hz <= '0;
        ipg_hz <= '0;
        per_hz <= '0;
      end else begin
        done   <= 1'b0;
        err    <= 1'b0;
        run    <= 1'b1;
        issued <= 1'b0;
        half_q <= (src_sel == SRC_FR2_HALF);
        frac_q <= frac_pick;
        ahb_q  <= ahb_div;
        ipg_q  <= ipg_div;
        per_q  <= per_div;
        if (src_sel == SRC_PLL) begin
          cur <= pll_hz;
          stg <= STG_AHB;
        end else begin
          cur <= pll_hz * DW'(FRAC_MUL);
          stg <= STG_FRAC;
        end
      end
    end else if (run) begin
      if (div_go) issued <= 1'b1;
      if (div_fin) begin
        issued <= 1'b0;
        case (stg)
          STG_FRAC: begin
            cur <= half_q ? (div_quo >> 1) : div_quo;
            stg <= STG_AHB;
          end
          STG_AHB: begin
            cur   <= div_quo;
            ahb_s <= sat(div_quo);
            stg   <= STG_IPG;
          end
          STG_IPG: begin
            cur   <= div_quo;
            ipg_s <= sat(div_quo);
            stg   <= STG_PER;
          end
          default: begin
            run    <= 1'b0;
            done   <= 1'b1;
            ahb_hz <= ahb_s;
            ipg_hz <= ipg_s;
            per_hz <= sat(div_quo);
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ccalc_clktree_freq.sv
module ccalc_clktree_freq
  import ccalc_pkg::*;
#(
  parameter int FRAC_W = 6,
  parameter int AHB_W  = 3,
  parameter int IPG_W  = 2,
  parameter int PER_W  = 6,
  parameter int OW     = 32,
  parameter int DW     = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pll_hi,
  input  logic [1:0]        src_sel,
  input  logic [FRAC_W-1:0] frac0,
  input  logic [FRAC_W-1:0] frac2,
  input  logic [AHB_W-1:0]  ahb_div,
  input  logic [IPG_W-1:0]  ipg_div,
  input  logic [PER_W-1:0]  per_div,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [OW-1:0]     ahb_hz,
  output logic [OW-1:0]     ipg_hz,
  output logic [OW-1:0]     per_hz,
  output logic [OW-1:0]     ref_hz,
  output logic [OW-1:0]     ref_div_hz
);
  localparam int W1 = (FRAC_W > AHB_W + 1) ? FRAC_W : AHB_W + 1;
  localparam int W2 = (W1 > IPG_W + 1) ? W1 : IPG_W + 1;
  localparam int VW = (W2 > PER_W + 1) ? W2 : PER_W + 1;

  logic          div_go, div_fin;
  logic [DW-1:0] div_num, div_quo;
  logic [VW-1:0] div_den;

  assign ref_hz     = OW'(REF_HZ);
  assign ref_div_hz = OW'(REF_HZ / REF_DIV);

  ccalc_ctrl #(
    .FRAC_W(FRAC_W), .AHB_W(AHB_W), .IPG_W(IPG_W), .PER_W(PER_W),
    .OW(OW), .DW(DW), .VW(VW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .pll_hi(pll_hi), .src_sel(src_sel),
    .frac0(frac0), .frac2(frac2), .ahb_div(ahb_div), .ipg_div(ipg_div),
    .per_div(per_div), .div_go(div_go), .div_num(div_num), .div_den(div_den),
    .div_fin(div_fin), .div_quo(div_quo), .busy(busy), .done(done), .err(err),
    .ahb_hz(ahb_hz), .ipg_hz(ipg_hz), .per_hz(per_hz)
  );

  ccalc_div #(.DW(DW), .VW(VW)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(div_den),
    .fin(div_fin), .quo(div_quo)
  );
endmodule

// File: rtl/ccalc_chk.sv
module ccalc_chk #(
  parameter int OW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [OW-1:0] ahb_hz,
  input logic [OW-1:0] ipg_hz,
  input logic [OW-1:0] per_hz
);
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !(done && busy)); // R10

  AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy || done); // R10

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done && $stable(ahb_hz) && $stable(ipg_hz) && $stable(per_hz) && $stable(err)); // R7

  AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    err |-> done && ahb_hz == '0 && ipg_hz == '0 && per_hz == '0); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    done && !err |-> ahb_hz >= ipg_hz && ipg_hz >= per_hz); // R4

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> busy || done); // R8
endmodule

bind ccalc_clktree_freq ccalc_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .err(err),
  .ahb_hz(ahb_hz), .ipg_hz(ipg_hz), .per_hz(per_hz)
);

// File: tb/sim_ccalc_clktree_freq.sv
module sim_ccalc_clktree_freq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        pll_hi = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic [5:0]  frac0 = 6'd0, frac2 = 6'd0;
  logic [2:0]  ahb_div = 3'd0;
  logic [1:0]  ipg_div = 2'd0;
  logic [5:0]  per_div = 6'd0;
  logic        busy, done, err;
  logic [31:0] ahb_hz, ipg_hz, per_hz, ref_hz, ref_div_hz;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lat    = 0;

  always #2.5 clk = ~clk;

  ccalc_clktree_freq u0 (
    .clk(clk), .rst(rst), .start(start), .pll_hi(pll_hi), .src_sel(src_sel),
    .frac0(frac0), .frac2(frac2), .ahb_div(ahb_div), .ipg_div(ipg_div),
    .per_div(per_div), .busy(busy), .done(done), .err(err), .ahb_hz(ahb_hz),
    .ipg_hz(ipg_hz), .per_hz(per_hz), .ref_hz(ref_hz), .ref_div_hz(ref_div_hz)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint sat32(input longint v);
    return (v > 64'sd4294967295) ? 64'sd4294967295 : v;
  endfunction

  task automatic model(input bit ph, input int ms, input int f0, input int f2,
                       input int a, input int i, input int p,
                       output longint ea, output longint ei, output longint ep,
                       output bit ee);
    longint pll, root;
    pll = 64'sd24000000 * (ph ? 22 : 20);
    ee = 1'b0;
    root = 0;
    case (ms)
      0: root = pll;
      1: if (f2 == 0) ee = 1'b1; else root = pll * 18 / f2;
      2: if (f0 == 0) ee = 1'b1; else root = pll * 18 / f0;
      default: if (f2 == 0) ee = 1'b1; else root = (pll * 18 / f2) / 2;
    endcase
    if (ee) begin
      ea = 0; ei = 0; ep = 0;
    end else begin
      ea = root / (a + 1);
      ei = ea / (i + 1);
      ep = ei / (p + 1);
    end
  endtask

  task automatic apply(input bit ph, input int ms, input int f0, input int f2,
                       input int a, input int i, input int p);
    pll_hi = ph; src_sel = 2'(ms); frac0 = 6'(f0); frac2 = 6'(f2);
    ahb_div = 3'(a); ipg_div = 2'(i); per_div = 6'(p);
  endtask

  task automatic pulse_and_wait();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_one(input bit ph, input int ms, input int f0, input int f2,
                         input int a, input int i, input int p);
    longint ea, ei, ep;
    bit ee;
    string rq;
    model(ph, ms, f0, f2, a, i, p, ea, ei, ep, ee);
    apply(ph, ms, f0, f2, a, i, p);
    @(negedge clk);
    pulse_and_wait();
    rq = (ms == 0) ? "R2" : "R3";
    if (ee) begin
      chk(done && err && lat == 1, "R6", "err flag/latency", longint'(lat), 1);
      chk(ahb_hz == 0 && ipg_hz == 0 && per_hz == 0, "R6", "zeroed results",
          longint'(ahb_hz), 0);
    end else begin
      chk(done && !err, "R6", "no error on valid fraction", longint'(err), 0);
      if (ea > 64'sd4294967295) rq = "R5";
      chk(longint'({32'd0, ahb_hz}) == sat32(ea), rq, "ahb_hz",
          longint'({32'd0, ahb_hz}), sat32(ea));
      chk(longint'({32'd0, ipg_hz}) == sat32(ei), "R4", "ipg_hz",
          longint'({32'd0, ipg_hz}), sat32(ei));
      chk(longint'({32'd0, per_hz}) == sat32(ep), "R4", "per_hz",
          longint'({32'd0, per_hz}), sat32(ep));
      chk(lat <= 4 * 64 + 16, "R10", "latency", longint'(lat), 272);
    end
  endtask

  initial begin
    int fv[6] = '{0, 1, 13, 18, 35, 63};
    longint ea, ei, ep;
    bit ee;
    logic [31:0] h_a, h_i, h_p;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !err, "R1", "flags after reset", longint'({busy, done, err}), 0);
    chk(ahb_hz == 0 && ipg_hz == 0 && per_hz == 0, "R1", "results after reset",
        longint'(ahb_hz), 0);
    // R9: constant reference outputs
    chk(ref_hz == 32'd24000000, "R9", "ref_hz", longint'(ref_hz), 24000000);
    chk(ref_div_hz == 32'd3000000, "R9", "ref_div_hz", longint'(ref_div_hz), 3000000);

    // R2 R3 R4 R5 R6: sweep of sources, PLL settings, fractions and dividers
    for (int ph = 0; ph < 2; ph++)
      for (int ms = 0; ms < 4; ms++)
        for (int k = 0; k < 6; k++)
          for (int a = 0; a < 8; a++) begin
            int f0, f2;
            f0 = (ms == 1 || ms == 3) ? 0 : fv[k];
            f2 = (ms == 2) ? 0 : fv[k];
            run_one(ph[0], ms, f0, f2, a, (a + fv[k]) % 4, (a * 9 + fv[k] * 5) % 64);
          end

    // R10: busy during a run
    apply(1'b1, 2, 7, 0, 5, 3, 63);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R10", "busy after start", longint'({busy, done}), 2);

    // R8: start while busy ignored, new inputs not sampled
    repeat (3) @(negedge clk);
    apply(1'b0, 0, 1, 1, 0, 0, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    model(1'b1, 2, 7, 0, 5, 3, 63, ea, ei, ep, ee);
    chk(longint'({32'd0, ahb_hz}) == ea, "R8", "ahb_hz after ignored start",
        longint'({32'd0, ahb_hz}), ea);
    chk(longint'({32'd0, per_hz}) == ep, "R8", "per_hz after ignored start",
        longint'({32'd0, per_hz}), ep);

    // R7: done and results hold while inputs change
    h_a = ahb_hz; h_i = ipg_hz; h_p = per_hz;
    apply(1'b0, 1, 0, 0, 7, 3, 9);
    repeat (6) @(negedge clk);
    chk(done && !err, "R7", "done held", longint'({done, err}), 2);
    chk(ahb_hz == h_a && ipg_hz == h_i && per_hz == h_p, "R7", "results held",
        longint'(ahb_hz), longint'(h_a));

    // R6: error run followed by a clean run clears err
    apply(1'b0, 3, 9, 0, 1, 1, 1);
    @(negedge clk);
    pulse_and_wait();
    chk(err && done && ahb_hz == 0, "R6", "zero frac2 with source 3",
        longint'(err), 1);
    run_one(1'b0, 3, 0, 9, 1, 1, 1);
    chk(!err, "R6", "err cleared by clean run", longint'(err), 0);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule